// File: doc/BRIEF.md
# Write-Protect and Power-Down Controller

This block sits between a serial command decoder and the data path of a small converter device that pairs a four-channel 8-bit output latch bank with a non-volatile store. For each decoded command it decides what actually happens. A write may reload an output latch, start programming of the store, do both, or do nothing. A read aimed at a converter register reloads that channel's latch from the stored value. The outcome depends on a write-enable latch and on an active-low write-protect pin. The same block keeps a power-down mode latch. It combines that latch with the power-down pin and the chip-select pin to produce the standby and high-impedance flags for the converter section and the storage section.

Two small state machines hold the state. The write-enable machine has the states `WEL_LOCKED` and `WEL_OPEN`. The enable command moves it from `WEL_LOCKED` to `WEL_OPEN`, and the disable command moves it back. The mode machine has the states `MODE_RUN` and `MODE_SLEEP`. The sleep command moves it from `MODE_RUN` to `MODE_SLEEP`, and the wake command moves it back. Both transitions are taken only while the power-down pin is high. Reset places both machines in their first state.

The write and read outcomes leave the block as registered single-cycle strobes, one clock after the command pulse. The channel number and the data source (command data or stored value) come with each latch strobe. The standby flags are combinational from the mode state and the pins.

Top module: `wp_pd_ctrl`

## Requirements
- R1: After reset the write-enable machine is in `WEL_LOCKED`, the mode machine is in `MODE_RUN`, and `dac_load` and `nv_prog` are low.
- R2: `cmd_op` encoding is 0 none, 1 read, 2 write, 3 write-enable, 4 write-disable, 5 sleep, 6 wake. Write-enable moves the write-enable machine to `WEL_OPEN` and write-disable moves it to `WEL_LOCKED`. A write to the general array (`cmd_dac`=0) raises `nv_prog` only in `WEL_OPEN`, whatever the level of `wp_n`.
- R3: A converter-register write (`cmd_dac`=1) with `wp_n` high in `WEL_OPEN` raises `dac_load` with `dac_src_store`=0 and raises `nv_prog` in the same cycle.
- R4: A converter-register write with `wp_n` high in `WEL_LOCKED` raises `dac_load` with `dac_src_store`=0 and keeps `nv_prog` low.
- R5: A converter-register write with `wp_n` low raises neither `dac_load` nor `nv_prog`.
- R6: A read with `cmd_dac`=1 raises `dac_load` with `dac_src_store`=1, in either write-enable state and at either `wp_n` level. A read with `cmd_dac`=0 raises no strobe.
- R7: While `pwrdn_n` is low, `dac_standby` and `out_hiz` are high, and the sleep and wake commands leave the mode machine unchanged.
- R8: While `pwrdn_n` is high, sleep moves the mode machine to `MODE_SLEEP` and wake moves it to `MODE_RUN`. `dac_standby` and `out_hiz` are high exactly in `MODE_SLEEP`.
- R9: `store_standby` is high exactly when the device is powered down (pin low or `MODE_SLEEP`) and `cs_hi` is high.
- R10: When reset is taken with `pwrdn_n` low, raising the pin later returns the device to normal mode, so `out_hiz` goes low.
- R11: `dac_load` and `nv_prog` are single-cycle pulses that appear in the cycle after the command pulse. `dac_chan` carries the command's channel whenever `dac_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is present |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_dac | input | 1 | 1 = target is a converter register, 0 = general array |
| cmd_chan | input | CH_W | Converter channel addressed by the command |
| wp_n | input | 1 | Write-protect pin, low blocks converter-register writes |
| pwrdn_n | input | 1 | Power-down pin, low forces power-down |
| cs_hi | input | 1 | Chip-select pin level (high = deselected) |
| dac_load | output | 1 | Strobe: reload one output latch |
| dac_chan | output | CH_W | Channel of the latch reload |
| dac_src_store | output | 1 | 1 = reload from stored value, 0 = from command data |
| nv_prog | output | 1 | Strobe: start non-volatile programming |
| dac_standby | output | 1 | Converter section in standby |
| out_hiz | output | 1 | Analog outputs high-impedance |
| store_standby | output | 1 | Storage section in standby (deep power-down) |

## Verification
The bench crosses both write-enable states with both protect levels for converter and array writes and for reads. A design that tied programming to protect alone, or that stopped the latch reload when write-enable is off, breaks a specific row of that table. It sends a wake command while the pin is low and then raises the pin. A design that let the pin-low period pass commands to the mode latch would come back awake instead of asleep. It takes reset with the pin low and checks that raising the pin returns normal mode, and it toggles chip select in both modes to catch a deep-standby flag that ignores the mode.

// File: rtl/wp_pd_pkg.sv
package wp_pd_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_WEN   = 3'd3,
        OP_WDIS  = 3'd4,
        OP_SLEEP = 3'd5,
        OP_WAKE  = 3'd6
    } cmd_op_e;

    typedef enum logic {
        WEL_LOCKED = 1'b0,
        WEL_OPEN   = 1'b1
    } wel_state_e;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } mode_state_e;
endpackage

// File: rtl/wp_pd_wel_fsm.sv
module wp_pd_wel_fsm
    import wp_pd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  cmd_op_e cmd_op,
    output logic    wel_on
);
    wel_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            unique case (state_q)
                WEL_LOCKED: if (cmd_op == OP_WEN)  state_d = WEL_OPEN;
                WEL_OPEN:   if (cmd_op == OP_WDIS) state_d = WEL_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        wel_on = (state_q == WEL_OPEN);
    end
endmodule

// File: rtl/wp_pd_mode_fsm.sv
module wp_pd_mode_fsm
    import wp_pd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  cmd_op_e cmd_op,
    input  logic    pwrdn_n,
    input  logic    cs_hi,
    output logic    sleep_q,
    output logic    dac_standby,
    output logic    out_hiz,
    output logic    store_standby
);
    mode_state_e state_q, state_d;
    logic        pd_active;

    always_comb begin
        state_d = state_q;
        if (cmd_valid && pwrdn_n) begin
            unique case (state_q)
                MODE_RUN:   if (cmd_op == OP_SLEEP) state_d = MODE_SLEEP;
                MODE_SLEEP: if (cmd_op == OP_WAKE)  state_d = MODE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        sleep_q       = (state_q == MODE_SLEEP);
        pd_active     = !pwrdn_n || sleep_q;
        dac_standby   = pd_active;
        out_hiz       = pd_active;
        store_standby = pd_active && cs_hi;
    end
endmodule

// File: rtl/wp_pd_route.sv
module wp_pd_route
    import wp_pd_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  cmd_op_e         cmd_op,
    input  logic            cmd_dac,
    input  logic [CH_W-1:0] cmd_chan,
    input  logic            wp_n,
    input  logic            wel_on,
    output logic            dac_load,
    output logic [CH_W-1:0] dac_chan,
    output logic            dac_src_store,
    output logic            nv_prog
);
    logic            ld_d, src_d, prog_d;

    always_comb begin
        ld_d   = 1'b0;
        src_d  = 1'b0;
        prog_d = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_WRITE: begin
                    if (cmd_dac) begin
                        if (wp_n) begin
                            ld_d   = 1'b1;
                            prog_d = wel_on;
                        end
                    end else begin
                        prog_d = wel_on;
                    end
                end
                OP_READ: begin
                    if (cmd_dac) begin
                        ld_d  = 1'b1;
                        src_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_load      <= 1'b0;
            dac_chan      <= '0;
            dac_src_store <= 1'b0;
            nv_prog       <= 1'b0;
        end else begin
            dac_load      <= ld_d;
            dac_chan      <= cmd_chan;
            dac_src_store <= src_d;
            nv_prog       <= prog_d;
        end
    end
endmodule

// File: rtl/wp_pd_ctrl.sv
module wp_pd_ctrl
    import wp_pd_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic            cmd_dac,
    input  logic [CH_W-1:0] cmd_chan,
    input  logic            wp_n,
    input  logic            pwrdn_n,
    input  logic            cs_hi,
    output logic            dac_load,
    output logic [CH_W-1:0] dac_chan,
    output logic            dac_src_store,
    output logic            nv_prog,
    output logic            dac_standby,
    output logic            out_hiz,
    output logic            store_standby
);
    cmd_op_e op;
    logic    wel_on;
    logic    sleep_q;

    always_comb op = cmd_op_e'(cmd_op);

    wp_pd_wel_fsm u_wel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .wel_on    (wel_on)
    );

    wp_pd_mode_fsm u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (op),
        .pwrdn_n       (pwrdn_n),
        .cs_hi         (cs_hi),
        .sleep_q       (sleep_q),
        .dac_standby   (dac_standby),
        .out_hiz       (out_hiz),
        .store_standby (store_standby)
    );

    wp_pd_route #(.CH_W(CH_W)) u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (op),
        .cmd_dac       (cmd_dac),
        .cmd_chan      (cmd_chan),
        .wp_n          (wp_n),
        .wel_on        (wel_on),
        .dac_load      (dac_load),
        .dac_chan      (dac_chan),
        .dac_src_store (dac_src_store),
        .nv_prog       (nv_prog)
    );
endmodule

// File: rtl/wp_pd_ctrl_chk.sv
module wp_pd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       cmd_dac,
    input logic       wp_n,
    input logic       pwrdn_n,
    input logic       cs_hi,
    input logic       dac_load,
    input logic       dac_src_store,
    input logic       nv_prog,
    input logic       out_hiz,
    input logic       store_standby,
    input logic       wel_on,
    input logic       sleep_q
);
    AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        nv_prog |-> $past(wel_on)); // R2

    AST_WEN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> wel_on); // R2

    AST_WP_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load && !dac_src_store) |-> $past(wp_n)); // R5

    AST_STORE_LOAD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_load && dac_src_store) |-> ($past(cmd_valid) && $past(cmd_op) == 3'd1 && $past(cmd_dac))); // R6

    AST_PIN_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |-> out_hiz); // R7

    AST_PIN_LOW_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !pwrdn_n) |=> (sleep_q == $past(sleep_q))); // R7

    AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && pwrdn_n && cmd_op == 3'd5) |=> sleep_q); // R8

    AST_DEEP_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        store_standby |-> (out_hiz && cs_hi)); // R9

    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> $past(cmd_valid)); // R11
endmodule

bind wp_pd_ctrl wp_pd_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_dac       (cmd_dac),
    .wp_n          (wp_n),
    .pwrdn_n       (pwrdn_n),
    .cs_hi         (cs_hi),
    .dac_load      (dac_load),
    .dac_src_store (dac_src_store),
    .nv_prog       (nv_prog),
    .out_hiz       (out_hiz),
    .store_standby (store_standby),
    .wel_on        (wel_on),
    .sleep_q       (sleep_q)
);

// File: tb/wp_pd_ctrl_test.sv
`timescale 1ns/1ps
module wp_pd_ctrl_test;
    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;
    localparam int NVEC   = 10;

    typedef struct packed {
        logic       wel;
        logic       wp;
        logic [2:0] op;
        logic       dac;
        logic [1:0] chan;
        logic       e_ld;
        logic       e_src;
        logic       e_pg;
    } vec_t;

    // op codes: 1 read, 2 write
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b1, 3'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1}, // R3
        '{1'b0, 1'b1, 3'd2, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b1, 1'b0, 3'd2, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b0, 1'b0, 3'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b1, 1'b0, 3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1}, // R2 protect ignored for array
        '{1'b0, 1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}, // R2
        '{1'b1, 1'b1, 3'd2, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1}, // R2
        '{1'b0, 1'b0, 3'd1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0}, // R6
        '{1'b1, 1'b1, 3'd1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0}, // R6
        '{1'b1, 1'b1, 3'd1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0}  // R6
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd0;
    logic            cmd_dac = 1'b0;
    logic [CH_W-1:0] cmd_chan = '0;
    logic            wp_n = 1'b1;
    logic            pwrdn_n = 1'b1;
    logic            cs_hi = 1'b0;
    logic            dac_load, dac_src_store, nv_prog;
    logic            dac_standby, out_hiz, store_standby;
    logic [CH_W-1:0] dac_chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wp_pd_ctrl #(.NUM_CH(NUM_CH)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dac(cmd_dac), .cmd_chan(cmd_chan), .wp_n(wp_n), .pwrdn_n(pwrdn_n),
        .cs_hi(cs_hi), .dac_load(dac_load), .dac_chan(dac_chan),
        .dac_src_store(dac_src_store), .nv_prog(nv_prog),
        .dac_standby(dac_standby), .out_hiz(out_hiz), .store_standby(store_standby)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one command pulse at a falling edge; return at the next falling
    // edge, where the registered strobes for that command are visible.
    task automatic issue(input logic [2:0] op, input logic dac, input logic [1:0] ch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dac = dac; cmd_chan = ch;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "dac_load", dac_load, 0);
        chk("R1", "nv_prog", nv_prog, 0);
        chk("R1", "out_hiz", out_hiz, 0);
        chk("R1", "store_standby", store_standby, 0);
        // R1 write-enable starts locked: array write does not program
        issue(3'd2, 1'b0, 2'd0);
        chk("R1", "nv_prog locked", nv_prog, 0);

        for (int i = 0; i < NVEC; i++) begin
            issue(TBL[i].wel ? 3'd3 : 3'd4, 1'b0, 2'd0);
            wp_n = TBL[i].wp;
            issue(TBL[i].op, TBL[i].dac, TBL[i].chan);
            chk($sformatf("R2-R6 row %0d", i), "dac_load", dac_load, TBL[i].e_ld);
            chk($sformatf("R2-R6 row %0d", i), "dac_src_store", dac_src_store, TBL[i].e_src);
            chk($sformatf("R2-R6 row %0d", i), "nv_prog", nv_prog, TBL[i].e_pg);
            if (TBL[i].e_ld)
                chk("R11", "dac_chan", dac_chan, TBL[i].chan);
            @(negedge clk);
            chk("R11", "dac_load pulse", dac_load, 0);
            chk("R11", "nv_prog pulse", nv_prog, 0);
        end
        wp_n = 1'b1;

        // R8 sleep / wake with pin high
        issue(3'd5, 1'b0, 2'd0);
        chk("R8", "out_hiz after sleep", out_hiz, 1);
        chk("R8", "dac_standby after sleep", dac_standby, 1);
        cs_hi = 1'b1; #1;
        chk("R9", "store_standby sleep cs high", store_standby, 1);
        cs_hi = 1'b0; #1;
        chk("R9", "store_standby sleep cs low", store_standby, 0);
        // R7 wake ignored while pin low
        pwrdn_n = 1'b0;
        issue(3'd6, 1'b0, 2'd0);
        chk("R7", "out_hiz pin low", out_hiz, 1);
        pwrdn_n = 1'b1; #1;
        chk("R7", "still asleep after ignored wake", out_hiz, 1);
        issue(3'd6, 1'b0, 2'd0);
        chk("R8", "out_hiz after wake", out_hiz, 0);
        chk("R8", "dac_standby after wake", dac_standby, 0);
        cs_hi = 1'b1; #1;
        chk("R9", "store_standby run cs high", store_standby, 0);
        // R7 sleep ignored while pin low
        pwrdn_n = 1'b0;
        issue(3'd5, 1'b0, 2'd0);
        chk("R9", "store_standby pin low cs high", store_standby, 1);
        pwrdn_n = 1'b1; #1;
        chk("R7", "awake after ignored sleep", out_hiz, 0);
        cs_hi = 1'b0;

        // R10 reset with pin low, then pin high
        pwrdn_n = 1'b0;
        do_reset();
        chk("R10", "out_hiz pin low after reset", out_hiz, 1);
        pwrdn_n = 1'b1; #1;
        chk("R10", "out_hiz after pin high", out_hiz, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule